// File: doc/BRIEF.md
# Coprocessor Busy Latch with Error Hold

This block sits between a math coprocessor and the CPU and produces the active-low busy signal that the CPU waits on. While no coprocessor error is outstanding, busy toward the CPU is a direct, combinational copy of the coprocessor's own busy output.

When the coprocessor raises its active-low error output, the block locks busy toward the CPU in the active state. It also raises an interrupt request meant for interrupt level 13. The CPU's own error input is expected to be tied inactive (high) elsewhere, so all exception reporting goes through the interrupt. Software acknowledges the exception by writing any value to I/O port 00F0h. That write drops both the lock and the interrupt request. Software clears the error inside the coprocessor only later, so the block refuses to lock again until it has first sampled the error output deasserted.

Top module: `npx_busy_gate`

## Requirements
- R1: While the lock is clear, `cpu_busy_n` equals `cop_busy_n` in the same cycle, with no register in the path.
- R2: An armed error (`cop_err_n` = 0) sampled at a rising edge sets the lock at that edge. From then on `cpu_busy_n` reads 0 whatever `cop_busy_n` does.
- R3: Once set, the lock stays set across any values of `cop_busy_n` and `cop_err_n` until a clearing write is sampled.
- R4: A clearing write is `io_wr` = 1 with `io_addr` equal to 16'h00F0 over all 16 bits. A write to any other address (for example 16'h01F0, 16'h00F1 or 16'h80F0), or an address of 16'h00F0 with `io_wr` = 0, leaves the lock unchanged.
- R5: After a clearing write, an error that is still asserted does not set the lock again. The error must be sampled deasserted at one or more edges before a later assertion can set it.
- R6: `irq13_req` rises at the same edge at which the lock is set and falls at the edge that samples the clearing write.
- R7: Reset (`rst_n` = 0, asynchronous) clears the lock and `irq13_req`. An error that is held asserted through reset does not set the lock until it has been sampled deasserted.
- R8: If a clearing write and an armed error are sampled at the same edge, the clearing write wins. The lock ends clear and the error must deassert before it can set the lock again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cop_busy_n | input | 1 | Coprocessor busy, active low |
| cop_err_n | input | 1 | Coprocessor error, active low |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O port address of the write |
| cpu_busy_n | output | 1 | Busy toward the CPU, active low |
| irq13_req | output | 1 | Interrupt request for level 13, active high |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle before each rising edge. They also assume that a port write is presented for exactly the cycle in which it is sampled. The bench meets this by changing every input only on the falling edge and by holding each step, strobe included, for one full cycle. The error input is treated as a level with no minimum width. The sweep therefore includes single-cycle error pulses and errors that overlap clearing writes.

// File: rtl/npx_busy_gate.sv
module npx_busy_gate #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLR_PORT = 'h00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cop_busy_n,
  input  logic              cop_err_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              cpu_busy_n,
  output logic              irq13_req
);

  logic lock_q;
  logic armed_q;
  logic ack_hit;
  logic err_on;

  assign ack_hit = io_wr && (io_addr == CLR_PORT);
  assign err_on  = !cop_err_n;

  // armed_q: error seen released since reset or the last acknowledge (R5, R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (ack_hit) armed_q <= 1'b0;
    else if (!err_on) armed_q <= 1'b1;
  end

  // lock_q: acknowledge has priority over a new error (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lock_q <= 1'b0;
    else if (ack_hit)           lock_q <= 1'b0;
    else if (err_on && armed_q) lock_q <= 1'b1;
  end

  assign cpu_busy_n = cop_busy_n && !lock_q;
  assign irq13_req  = lock_q;

endmodule

module npx_busy_gate_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLR_PORT = 'h00F0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cop_busy_n,
  input logic              cop_err_n,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic              cpu_busy_n,
  input logic              irq13_req
);

  logic ack;
  assign ack = io_wr && (io_addr == CLR_PORT);

  a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !irq13_req |-> (cpu_busy_n == cop_busy_n));

  a_r2_forced: assert property (@(posedge clk) disable iff (!rst_n)
    irq13_req |-> !cpu_busy_n);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq13_req && !ack) |=> irq13_req);

  a_r4_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq13_req);

  a_r2_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq13_req) |-> $past(!cop_err_n));

  a_r8_no_set_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq13_req) |-> !$past(ack));

  a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cop_err_n) ##1 !cop_err_n |=> !irq13_req);

endmodule

bind npx_busy_gate npx_busy_gate_chk #(.ADDR_W(ADDR_W), .CLR_PORT(CLR_PORT)) u_chk (.*);

// File: tb/sim_npx_busy_gate.sv
module sim_npx_busy_gate;
  localparam int P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cop_busy_n = 1'b1;
  logic cop_err_n = 1'b1;
  logic io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic cpu_busy_n;
  logic irq13_req;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_lock = 1'b0;
  bit exp_arm = 1'b0;

  always #(P/2) clk = ~clk;

  npx_busy_gate u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit b, input bit e, input bit w, input logic [15:0] a);
    @(negedge clk);
    cop_busy_n = b; cop_err_n = e; io_wr = w; io_addr = a;
    #1;
    chk(exp_lock ? "R2 forced busy" : "R1 pass-through", cpu_busy_n, b & ~exp_lock);
    @(posedge clk);
    if (w && a == 16'h00F0) begin
      exp_lock = 1'b0; exp_arm = 1'b0;
    end else begin
      if (!e && exp_arm) exp_lock = 1'b1;
      if (e) exp_arm = 1'b1;
    end
    #(P/4);
  endtask

  function automatic logic [15:0] pick(input int s);
    case (s)
      0: return 16'h00F0;
      1: return 16'h01F0;
      2: return 16'h00F1;
      default: return 16'h80F0;
    endcase
  endfunction

  initial begin
    #(200000*P);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cop_err_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset irq", irq13_req, 1'b0);
    chk("R7 reset busy", cpu_busy_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 0, 0); chk("R7 err held through reset", irq13_req, 0);
    step(1, 0, 0, 0); chk("R7 err held through reset", irq13_req, 0);
    step(1, 1, 0, 0); chk("R7 release", irq13_req, 0);
    step(1, 0, 0, 0); chk("R2 R6 set on error", irq13_req, 1);
    step(1, 1, 0, 0); chk("R3 hold after err release", irq13_req, 1);
    step(0, 1, 0, 0); chk("R3 hold with busy", irq13_req, 1);
    step(1, 1, 1, 16'h01F0); chk("R4 addr 01F0 ignored", irq13_req, 1);
    step(1, 1, 1, 16'h00F1); chk("R4 addr 00F1 ignored", irq13_req, 1);
    step(1, 1, 1, 16'h80F0); chk("R4 addr 80F0 ignored", irq13_req, 1);
    step(1, 1, 0, 16'h00F0); chk("R4 no strobe ignored", irq13_req, 1);
    step(1, 0, 0, 0); chk("R3 hold on reassert", irq13_req, 1);
    step(1, 0, 1, 16'h00F0); chk("R6 clear write", irq13_req, 0);
    #1; chk("R1 follow after clear", cpu_busy_n, 1);
    step(1, 0, 0, 0); chk("R5 no relock", irq13_req, 0);
    step(1, 0, 0, 0); chk("R5 no relock", irq13_req, 0);
    step(1, 1, 0, 0); chk("R5 release", irq13_req, 0);
    step(1, 0, 0, 0); chk("R5 relock after release", irq13_req, 1);
    step(1, 1, 1, 16'h00F0); chk("R6 clear", irq13_req, 0);
    step(1, 1, 0, 0);
    step(1, 0, 1, 16'h00F0); chk("R8 clear wins", irq13_req, 0);
    step(1, 0, 0, 0); chk("R8 needs release", irq13_req, 0);

    for (int i = 0; i < 4096; i++) begin
      int v;
      v = (i * 13 + (i >> 3) + (i >> 7)) % 32;
      step(v[0], v[1] | v[2], v[3], pick(v[4] ? (i % 4) : 0));
      chk(exp_lock ? "R3 R6 sweep lock" : "R4 R5 R8 sweep clear", irq13_req, exp_lock);
    end

    @(negedge clk); rst_n = 1'b0; #1;
    chk("R7 async reset", irq13_req, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule